// File: doc/BRIEF.md
# Scatter-gather stream-to-memory engine

This block takes packets arriving on a 32-bit data stream and stores them in memory buffers described by a linked list of descriptors. Each descriptor is fetched through a simple memory port before any data is taken. Beats then fill the descriptor's buffer until either its capacity is used up or the packet ends. A packet may span several descriptors. When a descriptor closes, the block writes back a status word that holds the completion flag, the frame-boundary flags and the byte count. If the descriptor ends a packet, the five application words most recently received on a separate control stream are written into it as well.

Software-side control arrives as plain register inputs. These are a run level, a current-pointer load and a tail-pointer write. A tail-pointer write re-arms an idle channel. The engine walks the list, follows each descriptor's next pointer, and parks as idle after it finishes the tail descriptor. A descriptor found already complete parks the channel as halted. A one-cycle pulse marks every finished packet.

Top module: `s2m_sg_engine`

## Requirements
- R1: `s_tready` is low in every cycle in which `run_i` is low, `idle_o` is high or `halted_o` is high.
- R2: Descriptor layout in word addresses from the descriptor pointer: +0 next pointer, +1 buffer address, +2 control (capacity in bytes in bits 22:0, a multiple of 4), +3 status, +4..+8 application words. Accepted beats are written in order to consecutive words starting at the buffer address. A descriptor closes after the smaller of its capacity and the rest of the packet.
- R3: If the fetched status word already has bit 31 set, `halted_o` rises and no beat is accepted until a pointer load or a tail write.
- R4: A control packet of exactly five words (the fifth flagged by `c_tlast`) replaces the stored application words. These are used at the next end of packet.
- R5: A control packet of any other length leaves the stored words unchanged and sets `ctl_err_o`, which stays high until reset.
- R6: When a descriptor receives the last beat of a packet, the stored words go to +4..+8 and status bit 26 is set. `done_o` then pulses high for exactly one cycle.
- R7: Status bit 27 is set when the previously closed descriptor ended a packet. This is also the case for the first descriptor after reset.
- R8: Every closed descriptor gets a status write with bit 31 set, the bytes written in bits 22:0 and zeros elsewhere. This status write is the descriptor's last memory write.
- R9: After the status write `cur_ptr_o` takes the next pointer. `idle_o` rises if the finished descriptor was the tail. A tail write clears `idle_o`.
- R10: After reset `idle_o` is high, `halted_o`, `done_o` and `ctl_err_o` are low, and `s_tready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Channel run enable |
| cur_load_i | input | 1 | Load `cur_ptr_i` as the current descriptor; clears halted |
| cur_ptr_i | input | ADDR_W | New current descriptor pointer |
| tail_wr_i | input | 1 | Write `tail_ptr_i`; clears idle and halted |
| tail_ptr_i | input | ADDR_W | New tail descriptor pointer |
| idle_o | output | 1 | Tail descriptor finished, waiting for a tail write |
| halted_o | output | 1 | A fetched descriptor was already complete |
| cur_ptr_o | output | ADDR_W | Current descriptor pointer |
| s_tdata | input | DATA_W | Data stream payload |
| s_tvalid | input | 1 | Data stream valid |
| s_tlast | input | 1 | Last beat of the packet |
| s_tready | output | 1 | Data stream ready |
| c_tdata | input | DATA_W | Control stream word |
| c_tvalid | input | 1 | Control stream valid |
| c_tlast | input | 1 | Last word of the control packet |
| c_tready | output | 1 | Control stream ready (always high) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the read |
| done_o | output | 1 | One-cycle pulse per finished packet |
| ctl_err_o | output | 1 | Sticky bad-length control packet flag |

## Verification
The assertions assume several things about the environment. Memory returns read data exactly one cycle after the access. Pointer loads and tail writes arrive only while the channel waits between descriptors, never while a descriptor is being filled. Every capacity is a non-zero multiple of four bytes. The stimulus follows these rules. It reprograms pointers only after the engine has gone idle or halted. It sends control packets only while the data stream is quiet, so the stored words never change while a packet is closing. It places descriptors and buffers in separate regions of the bench memory, so data writes never overlap a descriptor.

// File: rtl/s2m_pkg.sv
package s2m_pkg;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_FETCH = 2'd1,
      ST_DATA  = 2'd2,
      ST_WBACK = 2'd3
   } eng_state_e;

   // word offsets inside a descriptor
   localparam int OFS_NEXT = 0;
   localparam int OFS_BUF  = 1;
   localparam int OFS_CTRL = 2;
   localparam int OFS_STAT = 3;
   localparam int OFS_APP  = 4;
   localparam int FETCH_N  = 4;

   // status / control bit positions
   localparam int LEN_BITS = 23;
   localparam int BIT_EOF  = 26;
   localparam int BIT_SOF  = 27;
   localparam int BIT_DONE = 31;

endpackage

// File: rtl/s2m_app_capture.sv
module s2m_app_capture #(
   parameter int DATA_W    = 32,
   parameter int APP_WORDS = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [DATA_W-1:0]                c_tdata,
   input  logic                             c_tvalid,
   input  logic                             c_tlast,
   output logic                             c_tready,
   output logic [APP_WORDS-1:0][DATA_W-1:0] app_o,
   output logic                             err_o
);

   localparam int CNT_W = $clog2(APP_WORDS + 2);

   logic [DATA_W-1:0] stage_q [APP_WORDS];
   logic [DATA_W-1:0] app_q   [APP_WORDS];
   logic [CNT_W-1:0]  cnt_q;
   logic              err_q;
   logic              commit;

   assign c_tready = 1'b1;
   assign commit   = c_tvalid && c_tlast && (cnt_q == CNT_W'(APP_WORDS - 1));

   for (genvar g = 0; g < APP_WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q[g] <= '0;
            app_q[g]   <= '0;
         end else begin
            if (c_tvalid && (cnt_q == CNT_W'(g)))
               stage_q[g] <= c_tdata;
            if (commit)
               app_q[g] <= (g == APP_WORDS - 1) ? c_tdata : stage_q[g];
         end
      end
      assign app_o[g] = app_q[g];
   end

   // word counter saturates one past the legal length
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (c_tvalid) begin
         if (c_tlast) begin
            cnt_q <= '0;
            if (!commit) err_q <= 1'b1;
         end else if (cnt_q != CNT_W'(APP_WORDS)) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign err_o = err_q;

   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

endmodule

// File: rtl/s2m_engine.sv
module s2m_engine
   import s2m_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int APP_WORDS = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             run_i,
   input  logic                             cur_load_i,
   input  logic [ADDR_W-1:0]                cur_ptr_i,
   input  logic                             tail_wr_i,
   input  logic [ADDR_W-1:0]                tail_ptr_i,
   input  logic [DATA_W-1:0]                s_tdata,
   input  logic                             s_tvalid,
   input  logic                             s_tlast,
   output logic                             s_tready,
   input  logic [APP_WORDS-1:0][DATA_W-1:0] app_i,
   output logic                             mem_en,
   output logic                             mem_we,
   output logic [ADDR_W-1:0]                mem_addr,
   output logic [DATA_W-1:0]                mem_wdata,
   input  logic [DATA_W-1:0]                mem_rdata,
   output logic                             idle_o,
   output logic                             halted_o,
   output logic [ADDR_W-1:0]                cur_ptr_o,
   output logic                             done_o
);

   localparam int SH     = $clog2(DATA_W / 8);
   localparam int BEAT_W = LEN_BITS - SH;
   localparam int IDX_W  = $clog2(APP_WORDS + FETCH_N + 1);

   eng_state_e        st_q;
   logic [ADDR_W-1:0] cur_q, tail_q, nxt_q, buf_q;
   logic [BEAT_W-1:0] cap_q, cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic              idle_q, halted_q, sof_q, eop_q, done_q;
   logic              room, beat, app_phase;
   logic [DATA_W-1:0] stat_word, app_sel;

   assign room      = (cnt_q != cap_q);
   assign s_tready  = (st_q == ST_DATA) && run_i && room;
   assign beat      = s_tready && s_tvalid;
   assign app_phase = eop_q && (idx_q < IDX_W'(APP_WORDS));

   always_comb begin
      stat_word                 = '0;
      stat_word[LEN_BITS-1:0]   = {cnt_q, {SH{1'b0}}};
      stat_word[BIT_EOF]        = eop_q;
      stat_word[BIT_SOF]        = sof_q;
      stat_word[BIT_DONE]       = 1'b1;
   end

   always_comb begin
      app_sel = '0;
      for (int k = 0; k < APP_WORDS; k++)
         if (idx_q == IDX_W'(k)) app_sel = app_i[k];
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_wdata = s_tdata;
      case (st_q)
         ST_FETCH: if (idx_q < IDX_W'(FETCH_N)) begin
            mem_en   = 1'b1;
            mem_addr = cur_q + ADDR_W'(idx_q);
         end
         ST_DATA: begin
            mem_en   = beat;
            mem_we   = beat;
            mem_addr = buf_q + ADDR_W'(cnt_q);
         end
         ST_WBACK: begin
            mem_en = 1'b1;
            mem_we = 1'b1;
            if (app_phase) begin
               mem_addr  = cur_q + ADDR_W'(OFS_APP) + ADDR_W'(idx_q);
               mem_wdata = app_sel;
            end else begin
               mem_addr  = cur_q + ADDR_W'(OFS_STAT);
               mem_wdata = stat_word;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_WAIT;
         cur_q    <= '0;
         tail_q   <= '0;
         nxt_q    <= '0;
         buf_q    <= '0;
         cap_q    <= '0;
         cnt_q    <= '0;
         idx_q    <= '0;
         idle_q   <= 1'b1;
         halted_q <= 1'b0;
         sof_q    <= 1'b1;
         eop_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_WAIT: if (run_i && !idle_q && !halted_q) begin
               st_q  <= ST_FETCH;
               idx_q <= '0;
            end
            ST_FETCH: begin
               idx_q <= idx_q + IDX_W'(1);
               if (idx_q == IDX_W'(OFS_NEXT + 1)) nxt_q <= mem_rdata[ADDR_W-1:0];
               if (idx_q == IDX_W'(OFS_BUF + 1))  buf_q <= mem_rdata[ADDR_W-1:0];
               if (idx_q == IDX_W'(OFS_CTRL + 1)) cap_q <= mem_rdata[LEN_BITS-1:SH];
               if (idx_q == IDX_W'(OFS_STAT + 1)) begin
                  if (mem_rdata[BIT_DONE]) begin
                     halted_q <= 1'b1;
                     st_q     <= ST_WAIT;
                  end else begin
                     st_q  <= ST_DATA;
                     cnt_q <= '0;
                     eop_q <= 1'b0;
                  end
               end
            end
            ST_DATA: begin
               if (cap_q == '0) begin
                  st_q  <= ST_WBACK;
                  idx_q <= '0;
               end else if (beat) begin
                  cnt_q <= cnt_q + BEAT_W'(1);
                  if (s_tlast) eop_q <= 1'b1;
                  if (s_tlast || ((cnt_q + BEAT_W'(1)) == cap_q)) begin
                     st_q  <= ST_WBACK;
                     idx_q <= '0;
                  end
               end
            end
            ST_WBACK: begin
               if (app_phase) begin
                  idx_q <= idx_q + IDX_W'(1);
               end else begin
                  done_q <= eop_q;
                  sof_q  <= eop_q;
                  cur_q  <= nxt_q;
                  if (cur_q == tail_q) idle_q <= 1'b1;
                  st_q   <= ST_WAIT;
               end
            end
            default: st_q <= ST_WAIT;
         endcase
         if (cur_load_i) begin
            cur_q    <= cur_ptr_i;
            halted_q <= 1'b0;
         end
         if (tail_wr_i) begin
            tail_q   <= tail_ptr_i;
            idle_q   <= 1'b0;
            halted_q <= 1'b0;
         end
      end
   end

   assign idle_o    = idle_q;
   assign halted_o  = halted_q;
   assign cur_ptr_o = cur_q;
   assign done_o    = done_q;

   a_r1_idle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q |-> !s_tready);
   a_r3_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |-> !s_tready);
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> (cnt_q < cap_q));

endmodule

// File: rtl/s2m_sg_engine.sv
module s2m_sg_engine #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int APP_WORDS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              cur_load_i,
   input  logic [ADDR_W-1:0] cur_ptr_i,
   input  logic              tail_wr_i,
   input  logic [ADDR_W-1:0] tail_ptr_i,
   output logic              idle_o,
   output logic              halted_o,
   output logic [ADDR_W-1:0] cur_ptr_o,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tvalid,
   input  logic              s_tlast,
   output logic              s_tready,
   input  logic [DATA_W-1:0] c_tdata,
   input  logic              c_tvalid,
   input  logic              c_tlast,
   output logic              c_tready,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done_o,
   output logic              ctl_err_o
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("s2m_sg_engine: descriptor words require DATA_W == 32");
   end
   if (ADDR_W < 4 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("s2m_sg_engine: ADDR_W must lie between 4 and DATA_W");
   end
   if (APP_WORDS < 1) begin : g_bad_app
      $error("s2m_sg_engine: APP_WORDS must be at least 1");
   end

   logic [APP_WORDS-1:0][DATA_W-1:0] app_words;

   s2m_app_capture #(
      .DATA_W    (DATA_W),
      .APP_WORDS (APP_WORDS)
   ) u_appcap (
      .clk      (clk),
      .rst_n    (rst_n),
      .c_tdata  (c_tdata),
      .c_tvalid (c_tvalid),
      .c_tlast  (c_tlast),
      .c_tready (c_tready),
      .app_o    (app_words),
      .err_o    (ctl_err_o)
   );

   s2m_engine #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .APP_WORDS (APP_WORDS)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_i),
      .cur_load_i (cur_load_i),
      .cur_ptr_i  (cur_ptr_i),
      .tail_wr_i  (tail_wr_i),
      .tail_ptr_i (tail_ptr_i),
      .s_tdata    (s_tdata),
      .s_tvalid   (s_tvalid),
      .s_tlast    (s_tlast),
      .s_tready   (s_tready),
      .app_i      (app_words),
      .mem_en     (mem_en),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .idle_o     (idle_o),
      .halted_o   (halted_o),
      .cur_ptr_o  (cur_ptr_o),
      .done_o     (done_o)
   );

endmodule

// File: tb/s2m_sg_engine_tb.sv
module s2m_sg_engine_tb;

   localparam int AW   = 10;
   localparam int DW   = 32;
   localparam int NAPP = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          run_i = 1'b0, cur_load_i = 1'b0, tail_wr_i = 1'b0;
   logic [AW-1:0] cur_ptr_i = '0, tail_ptr_i = '0;
   logic          idle_o, halted_o, s_tready, c_tready, mem_en, mem_we, done_o, ctl_err_o;
   logic [AW-1:0] cur_ptr_o, mem_addr;
   logic [DW-1:0] s_tdata = '0, c_tdata = '0, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          s_tvalid = 1'b0, s_tlast = 1'b0, c_tvalid = 1'b0, c_tlast = 1'b0;

   s2m_sg_engine #(.ADDR_W(AW), .DATA_W(DW), .APP_WORDS(NAPP)) u_dut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .cur_load_i(cur_load_i),
      .cur_ptr_i(cur_ptr_i), .tail_wr_i(tail_wr_i), .tail_ptr_i(tail_ptr_i),
      .idle_o(idle_o), .halted_o(halted_o), .cur_ptr_o(cur_ptr_o),
      .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
      .c_tdata(c_tdata), .c_tvalid(c_tvalid), .c_tlast(c_tlast), .c_tready(c_tready),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done_o(done_o), .ctl_err_o(ctl_err_o));

   // memory model: one-cycle read latency
   logic [DW-1:0] mem [1024];
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         mem_rdata <= mem[mem_addr];
      end
   end

   int n_cmp = 0, n_bad = 0;
   bit ended = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_all();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // reference model state
   logic [63:0]   expq[$];
   logic [AW-1:0] m_cur, m_tail, m_nxt, m_buf;
   int            m_cap, m_cnt;
   bit            m_loaded = 0, m_sof = 1, m_err = 0, m_idle = 1;
   logic [DW-1:0] m_app [NAPP];
   logic [DW-1:0] m_stage [NAPP];
   int            m_ccnt = 0, exp_done = 0, got_done = 0;

   initial for (int i = 0; i < NAPP; i++) m_app[i] = '0;

   task automatic push_w(input logic [AW-1:0] a, input logic [DW-1:0] d);
      expq.push_back({22'd0, a, d});
   endtask

   task automatic close_desc(input bit eop);
      logic [DW-1:0] st;
      if (eop) for (int i = 0; i < NAPP; i++) push_w(m_cur + AW'(4 + i), m_app[i]);
      st = 32'h8000_0000 | (32'(m_sof) << 27) | (32'(eop) << 26) | 32'(m_cnt * 4);
      push_w(m_cur + AW'(3), st);
      if (eop) exp_done++;
      m_sof = eop;
      if (m_cur == m_tail) m_idle = 1;
      m_cur = m_nxt;
      m_loaded = 0;
   endtask

   task automatic model_beat(input logic [DW-1:0] d, input bit last);
      if (!m_loaded) begin
         m_nxt = mem[m_cur][AW-1:0];
         m_buf = mem[m_cur + AW'(1)][AW-1:0];
         m_cap = int'(mem[m_cur + AW'(2)][22:2]);
         m_cnt = 0;
         m_loaded = 1;
      end
      push_w(m_buf + AW'(m_cnt), d);
      m_cnt++;
      if (last || m_cnt == m_cap) close_desc(last);
   endtask

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         if (c_tvalid) begin
            if (m_ccnt < NAPP) m_stage[m_ccnt] = c_tdata;
            if (c_tlast) begin
               if (m_ccnt == NAPP - 1) for (int i = 0; i < NAPP; i++) m_app[i] = m_stage[i];
               else m_err = 1;
               m_ccnt = 0;
            end else if (m_ccnt < NAPP) m_ccnt++;
         end
         if (s_tvalid && s_tready) model_beat(s_tdata, s_tlast);
         if (mem_en && mem_we) begin
            if (expq.size() == 0)
               chk(0, "R2 R6 R8 unexpected write", {22'd0, mem_addr, mem_wdata}, 64'd0);
            else begin
               logic [63:0] e;
               e = expq.pop_front();
               chk(e == {22'd0, mem_addr, mem_wdata}, "R2 R6 R8 write", {22'd0, mem_addr, mem_wdata}, e);
            end
         end
         if (!run_i || idle_o || halted_o)
            chk(!s_tready, "R1 ready gated", 64'(s_tready), 64'd0);
         if (done_o) got_done++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic mkdesc(input int a, input int nxt, input int bufa, input int capb, input logic [31:0] st);
      mem[a]     = 32'(nxt);
      mem[a + 1] = 32'(bufa);
      mem[a + 2] = 32'(capb);
      mem[a + 3] = st;
      for (int i = 4; i < 9; i++) mem[a + i] = 32'hFFFF_FFFF;
   endtask

   task automatic set_ptrs(input logic [AW-1:0] c, input bit ld, input logic [AW-1:0] t);
      @(posedge clk); #1;
      cur_load_i = ld; cur_ptr_i = c; tail_wr_i = 1; tail_ptr_i = t;
      if (ld) m_cur = c;
      m_tail = t; m_idle = 0;
      @(posedge clk); #1;
      cur_load_i = 0; tail_wr_i = 0;
   endtask

   task automatic beat(input logic [DW-1:0] d, input bit last);
      @(posedge clk); #1;
      s_tvalid = 1; s_tdata = d; s_tlast = last;
      @(negedge clk);
      while (!s_tready) @(negedge clk);
      @(posedge clk); #1;
      s_tvalid = 0; s_tlast = 0;
   endtask

   task automatic pkt(input logic [DW-1:0] base, input int n);
      for (int i = 0; i < n; i++) beat(base + DW'(i), i == n - 1);
   endtask

   task automatic cpkt(input logic [DW-1:0] base, input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         c_tvalid = 1; c_tdata = base + DW'(i); c_tlast = (i == n - 1);
      end
      @(posedge clk); #1;
      c_tvalid = 0; c_tlast = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "watchdog", 64'd0, 64'd1);
      finish_all();
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      tick(4);
      rst_n = 1;
      tick(1);
      @(negedge clk);
      chk(idle_o == 1, "R10 idle after reset", 64'(idle_o), 64'd1);
      chk(halted_o == 0, "R10 halted after reset", 64'(halted_o), 64'd0);
      chk(s_tready == 0, "R10 ready after reset", 64'(s_tready), 64'd0);
      chk(done_o == 0 && ctl_err_o == 0, "R10 done/err after reset", 64'({done_o, ctl_err_o}), 64'd0);

      mkdesc('h100, 'h110, 'h200, 16, 0);
      mkdesc('h110, 'h120, 'h210, 16, 0);
      mkdesc('h120, 'h130, 'h220, 16, 0);
      mkdesc('h130, 'h140, 'h230, 16, 0);
      mkdesc('h140, 'h150, 'h240, 8, 0);
      mkdesc('h160, 'h170, 'h260, 16, 32'h8000_0000);
      run_i = 1;
      set_ptrs(AW'('h100), 1, AW'('h130));

      cpkt(32'hA000, 5);
      pkt(32'h1000, 3);                 // one descriptor, short packet
      cpkt(32'hB000, 3);                // bad length
      tick(3);
      @(negedge clk);
      chk(ctl_err_o == 1, "R5 error flag", 64'(ctl_err_o), 64'd1);
      cpkt(32'hC000, 5);
      pkt(32'h2000, 6);                 // spans two descriptors
      pkt(32'h3000, 4);                 // exactly fills the tail descriptor
      tick(15);
      @(negedge clk);
      chk(idle_o == 1, "R9 idle at tail", 64'(idle_o), 64'd1);
      chk(cur_ptr_o == AW'('h140), "R9 pointer advanced", 64'(cur_ptr_o), 64'h140);
      chk(got_done == 3, "R6 done pulses", 64'(got_done), 64'd3);
      chk(mem['h104] == 32'hA000, "R4 app word first packet", 64'(mem['h104]), 64'hA000);
      chk(mem['h124] == 32'hC000, "R4 app word after bad packet", 64'(mem['h124]), 64'hC000);
      chk(mem['h113] == 32'h8800_0010, "R7 sof without eof", 64'(mem['h113]), 64'h8800_0010);
      chk(mem['h123] == 32'h8400_0008, "R7 eof without sof", 64'(mem['h123]), 64'h8400_0008);
      chk(mem['h133] == 32'h8C00_0010, "R8 full descriptor status", 64'(mem['h133]), 64'h8C00_0010);

      // idle: valid held, must not be taken (R1 checked every clock)
      @(posedge clk); #1;
      s_tvalid = 1; s_tdata = 32'hDEAD;
      tick(8);
      s_tvalid = 0;
      // stopped but re-armed
      run_i = 0;
      set_ptrs(AW'('h140), 0, AW'('h140));
      @(negedge clk);
      chk(idle_o == 0, "R9 tail write clears idle", 64'(idle_o), 64'd0);
      @(posedge clk); #1;
      s_tvalid = 1; s_tdata = 32'hBEEF;
      tick(8);
      s_tvalid = 0;
      run_i = 1;
      pkt(32'h4000, 2);
      tick(15);
      @(negedge clk);
      chk(mem['h240] == 32'h4000, "R1 first beat after run", 64'(mem['h240]), 64'h4000);
      chk(cur_ptr_o == AW'('h150) && idle_o, "R9 second tail", 64'(cur_ptr_o), 64'h150);

      // halt on a descriptor that is already complete
      set_ptrs(AW'('h160), 1, AW'('h160));
      tick(20);
      @(posedge clk); #1;
      s_tvalid = 1; s_tdata = 32'h5555;
      tick(5);
      @(negedge clk);
      chk(halted_o == 1, "R3 halted", 64'(halted_o), 64'd1);
      chk(s_tready == 0, "R3 no ready", 64'(s_tready), 64'd0);
      @(posedge clk); #1;
      s_tvalid = 0;
      tick(2);
      @(negedge clk);
      chk(mem['h163] == 32'h8000_0000, "R3 status untouched", 64'(mem['h163]), 64'h8000_0000);
      chk(got_done == exp_done, "R6 total done pulses", 64'(got_done), 64'(exp_done));
      chk(ctl_err_o == m_err, "R5 sticky error", 64'(ctl_err_o), 64'(m_err));
      chk(idle_o == m_idle, "R9 idle model", 64'(idle_o), 64'(m_idle));
      chk(expq.size() == 0, "R8 all writes seen", 64'(expq.size()), 64'd0);
      finish_all();
   end

endmodule